// File: doc/BRIEF.md
# Timer Channel Port Bank

This block holds the programming state of four timer channels as a processor sees them through four consecutive byte-wide I/O ports at 0x80 to 0x83. Each channel keeps a control byte, a time-constant byte and a counter byte. One write strobe serves three kinds of register. A control word may announce that a time constant comes next. If it does, the channel's next write is taken as the constant. If no constant is pending, data bit 0 decides whether the byte is a new control word or, on channel 0 only, the base of the shared interrupt vector.

The counting engine and interrupt logic are not part of this block. The counter byte is loaded whenever a time constant is stored, so reads through the ports show the programmed value. Channels 0 and 1 also drive 9-bit divisors that serial ports use to derive their bit rate (a 115200 reference divided by the divisor). A time constant of zero stands for a divisor of 256.

Top module: `tmr_port_bank`

## Requirements
- R1: Only port addresses 0x80 to 0x83 reach the channels, and address bits 1:0 select the channel. A write to any other address changes no channel state and no output. A read at any other address returns 0.
- R2: When the selected channel's control bit 2 is set, a write stores the data as that channel's time constant and loads it into the counter. It also clears control bits 2 and 1 and leaves the other control bits unchanged.
- R3: When control bit 2 is clear and data bit 0 is 1, a write replaces the whole control byte.
- R4: When control bit 2 is clear and data bit 0 is 0, a write to channel 0 sets vec_base to the data with bits 2:0 forced to 0. The same write to channels 1 to 3 changes nothing.
- R5: baud_div0 and baud_div1 equal the time constant of channel 0 and channel 1 respectively, or 256 when that constant is 0.
- R6: While rd_en is high at a channel address, rd_data shows that channel's counter if its control bit 6 is set, and 0 otherwise. rd_data is 0 while rd_en is low.
- R7: After reset, every control, time-constant and counter byte is 0, vec_base is 0 and both divisors are 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Read data, combinational |
| baud_div0 | output | 9 | Serial divisor from channel 0 (1 to 256) |
| baud_div1 | output | 9 | Serial divisor from channel 1 (1 to 256) |
| vec_base | output | 8 | Interrupt vector base, bits 2:0 always 0 |

## Verification
The assertions check the write routing on every cycle. They cover how a pending constant is stored and clears its flag, how a control word replaces the control byte, how the vector register holds unless channel 0 writes to it, the legal divisor range, and the zero read when counter mode is off. Some effects only show across a sequence of writes, so only the bench scenarios can show them. These include the flag that a control word sets and the next write consumes, a constant written to one channel that leaves the others unchanged, and zero mapping to 256 for each of the 256 constants.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int BYTE_W      = 8;
    localparam int BIT_CTL_SEL = 0;
    localparam int BIT_RELOAD  = 1;
    localparam int BIT_TC_NEXT = 2;
    localparam int BIT_CNT_RD  = 6;
    localparam int VEC_LOW_W   = 3;

    typedef struct packed {
        logic [BYTE_W-1:0] ctl;
        logic [BYTE_W-1:0] tc;
        logic [BYTE_W-1:0] cnt;
    } chan_regs_t;
endpackage

// File: rtl/tmr_addr_dec.sv
module tmr_addr_dec #(
    parameter int          ADDR_W    = 8,
    parameter int          NUM_CH    = 4,
    parameter logic [7:0]  BASE_ADDR = 8'h80,
    localparam int         CH_W      = $clog2(NUM_CH)
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [CH_W-1:0]   ch
);
    always_comb begin
        hit = (addr[ADDR_W-1:CH_W] == BASE_ADDR[ADDR_W-1:CH_W]);
        ch  = addr[CH_W-1:0];
    end
endmodule

// File: rtl/tmr_chan.sv
module tmr_chan
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [BYTE_W-1:0] wdata,
    output chan_regs_t        regs_o
);
    chan_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (sel_wr) begin
            if (regs_q.ctl[BIT_TC_NEXT]) begin
                regs_d.tc               = wdata;
                regs_d.cnt              = wdata;
                regs_d.ctl[BIT_TC_NEXT] = 1'b0;
                regs_d.ctl[BIT_RELOAD]  = 1'b0;
            end else if (wdata[BIT_CTL_SEL]) begin
                regs_d.ctl = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/tmr_baud_div.sv
module tmr_baud_div #(
    parameter  int TC_W  = 8,
    localparam int DIV_W = TC_W + 1
) (
    input  logic [TC_W-1:0]  tc,
    output logic [DIV_W-1:0] div
);
    always_comb begin
        if (tc == '0) div = DIV_W'(1) << TC_W;
        else          div = {1'b0, tc};
    end
endmodule

// File: rtl/tmr_port_bank.sv
module tmr_port_bank
    import tmr_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         NUM_CH    = 4,
    parameter int         NUM_BAUD  = 2,
    parameter logic [7:0] BASE_ADDR = 8'h80,
    localparam int        CH_W      = $clog2(NUM_CH),
    localparam int        DIV_W     = BYTE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic [DIV_W-1:0]  baud_div0,
    output logic [DIV_W-1:0]  baud_div1,
    output logic [BYTE_W-1:0] vec_base
);
    logic                           hit;
    logic [CH_W-1:0]                ch;
    chan_regs_t [NUM_CH-1:0]        regs;
    logic [NUM_CH-1:0][BYTE_W-1:0]  ctl_all;
    logic [NUM_CH-1:0][BYTE_W-1:0]  tc_all;
    logic [NUM_BAUD-1:0][DIV_W-1:0] div_all;
    logic [BYTE_W-1:0]              vec_d, vec_q;
    logic                           unused_ok;

    tmr_addr_dec #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .BASE_ADDR(BASE_ADDR)) u_dec (
        .addr (io_addr),
        .hit  (hit),
        .ch   (ch)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        tmr_chan u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .sel_wr (wr_en && hit && (ch == CH_W'(i))),
            .wdata  (wr_data),
            .regs_o (regs[i])
        );
        assign ctl_all[i] = regs[i].ctl;
        assign tc_all[i]  = regs[i].tc;
    end

    for (genvar b = 0; b < NUM_BAUD; b++) begin : g_baud
        tmr_baud_div #(.TC_W(BYTE_W)) u_div (
            .tc  (tc_all[b]),
            .div (div_all[b])
        );
    end

    assign baud_div0 = div_all[0];
    assign baud_div1 = div_all[1];

    always_comb begin
        vec_d = vec_q;
        if (wr_en && hit && (ch == '0) && !ctl_all[0][BIT_TC_NEXT]
            && !wr_data[BIT_CTL_SEL])
            vec_d = {wr_data[BYTE_W-1:VEC_LOW_W], {VEC_LOW_W{1'b0}}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) vec_q <= '0;
        else        vec_q <= vec_d;
    end

    assign vec_base = vec_q;

    always_comb begin
        rd_data = '0;
        if (rd_en && hit && regs[ch].ctl[BIT_CNT_RD])
            rd_data = regs[ch].cnt;
    end

    assign unused_ok = ^{ctl_all, tc_all};
endmodule

// File: rtl/tmr_port_bank_chk.sv
module tmr_port_bank_chk #(
    parameter int NUM_CH = 4,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          wr_en,
    input logic [7:0]                    wr_data,
    input logic                          rd_en,
    input logic [7:0]                    rd_data,
    input logic [8:0]                    baud_div0,
    input logic [8:0]                    baud_div1,
    input logic [7:0]                    vec_base,
    input logic                          hit,
    input logic [CH_W-1:0]               ch,
    input logic [NUM_CH-1:0][7:0]        ctl_all,
    input logic [NUM_CH-1:0][7:0]        tc_all
);
    p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit) |=> ($stable(ctl_all) && $stable(tc_all) && $stable(vec_base)));

    p_tc_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && ctl_all[ch][2]) |=>
        (tc_all[$past(ch)] == $past(wr_data)) && (ctl_all[$past(ch)][2:1] == 2'b00));

    p_ctl_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && hit && !ctl_all[ch][2] && wr_data[0]) |=>
        (ctl_all[$past(ch)] == $past(wr_data)));

    p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit && (ch == '0)) |=> $stable(vec_base));

    p_div_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_div0 != 9'd0) && (baud_div0 <= 9'd256) &&
        (baud_div1 != 9'd0) && (baud_div1 <= 9'd256));

    p_rd_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_en || !hit || !ctl_all[ch][6]) |-> (rd_data == 8'd0));
endmodule

bind tmr_port_bank tmr_port_bank_chk #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/sim_tmr_port_bank.sv
`timescale 1ns/1ps
module sim_tmr_port_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] io_addr = 8'h00;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [8:0] baud_div0, baud_div1;
    logic [7:0] vec_base;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_ctl [4];
    logic [7:0] m_cnt [4];
    logic [7:0] m_tc  [4];
    logic [7:0] m_vec;

    always #2.5 clk = ~clk;

    tmr_port_bank u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_div(input logic [7:0] t);
        return (t == 8'd0) ? 256 : int'(t);
    endfunction

    // model from the requirements
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a[7:2] == 6'b100000) begin
            int c = int'(a[1:0]);
            if (m_ctl[c][2]) begin
                m_tc[c] = d; m_cnt[c] = d; m_ctl[c][2] = 1'b0; m_ctl[c][1] = 1'b0;
            end else if (d[0]) begin
                m_ctl[c] = d;
            end else if (c == 0) begin
                m_vec = {d[7:3], 3'b000};
            end
        end
    endtask

    task automatic rd_check(input logic [7:0] a, input string req);
        int exp;
        @(negedge clk);
        io_addr = a; rd_en = 1'b1;
        #1;
        exp = 0;
        if (a[7:2] == 6'b100000 && m_ctl[a[1:0]][6]) exp = int'(m_cnt[a[1:0]]);
        chk(req, int'(rd_data), exp);
        rd_en = 1'b0;
    endtask

    task automatic out_check(input string req);
        chk(req, int'(baud_div0), exp_div(m_tc[0]));
        chk(req, int'(baud_div1), exp_div(m_tc[1]));
        chk(req, int'(vec_base), int'(m_vec));
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin m_ctl[i] = 0; m_cnt[i] = 0; m_tc[i] = 0; end
        m_vec = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7 reset state
        chk("R7", int'(baud_div0), 256);
        chk("R7", int'(baud_div1), 256);
        chk("R7", int'(vec_base), 0);
        for (int c = 0; c < 4; c++) begin
            wr(8'h80 + 8'(c), 8'h41);
            rd_check(8'h80 + 8'(c), "R7");
        end
        // R2/R5/R6 sweep of every constant on every channel
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 256; v++) begin
                wr(8'h80 + 8'(c), 8'h45);
                wr(8'h80 + 8'(c), 8'(v));
                rd_check(8'h80 + 8'(c), "R2");
                out_check("R5");
            end
        end
        // R2: pending flag consumed; next write with bit0 clear is vector or nothing
        for (int c = 0; c < 4; c++) begin
            for (int v = 0; v < 256; v += 2) begin
                wr(8'h80 + 8'(c), 8'(v));
                out_check("R4");
                rd_check(8'h80 + 8'(c), "R4");
            end
        end
        // R3: control word without counter mode gates read to 0
        for (int c = 0; c < 4; c++) begin
            wr(8'h80 + 8'(c), 8'h33);
            rd_check(8'h80 + 8'(c), "R3");
            wr(8'h80 + 8'(c), 8'h43);
            rd_check(8'h80 + 8'(c), "R3");
        end
        // R2: constant write clears bits 2:1, keeps bit 6
        wr(8'h81, 8'h47);
        wr(8'h81, 8'h05);
        rd_check(8'h81, "R2");
        out_check("R2");
        wr(8'h81, 8'h02);
        rd_check(8'h81, "R2");
        // R1: writes outside the port range do nothing
        wr(8'h80, 8'h45);
        for (int a = 0; a < 256; a += 7) begin
            if (a[7:2] != 6'b100000) begin
                wr(8'(a), 8'h10);
                rd_check(8'(a), "R1");
            end
        end
        wr(8'h80, 8'h9A);
        rd_check(8'h80, "R1");
        out_check("R1");
        // R6: rd_en low gives 0
        @(negedge clk);
        io_addr = 8'h80; rd_en = 1'b0;
        #1 chk("R6", int'(rd_data), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule